// File: doc/BRIEF.md
# Banked GPIO Controller with Trigger Detection

This block is a memory-mapped general-purpose I/O controller for up to 96 pins. The default build populates 70. Each per-pin setting is kept in a group of 32-bit words, one word for every 32 pins. The settings are:

- direction (drive or listen)
- output value
- interrupt enable
- trigger kind (level or edge)
- trigger sense (high/rising or low/falling)
- pending status

Software reaches pin `n` in the word at the setting's base address plus `(n/32)*4`, bit `n%32`.

Pin inputs pass through a synchronizer. They are then checked against each pin's trigger mode, and the result is captured in a pending-status word. Status bits for edge triggers are cleared by writing one. The enabled, pending bits are ORed into one registered interrupt line for the parent interrupt controller. The bus is a simple word-addressed read/write port. Read data returns one cycle after the read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every setting and status bit is zero, `pin_oe`, `pin_out` and `irq` are low, and reads of every word return zero.
- R2: Base byte addresses are 0x014 (direction), 0x024 (output value / pin level), 0x044 (interrupt enable), 0x104 (trigger sense), 0x114 (trigger kind) and 0x124 (status). Pin n is at base+(n/32)*4, bit n%32.
- R3: A direction bit of 1 drives `pin_oe` high for that pin, and 0 makes it an input. A write to the output-value word sets `pin_out`. Settings hold when no write targets them.
- R4: A read of the output-value word returns the pin input levels after a two-flop synchronizer. A change is visible to a read whose strobe is sampled two or more rising edges after the first edge that samples the change.
- R5: `bus_rvalid` is high exactly one cycle after `bus_re`, with `bus_rdata` valid in that cycle. `bus_rdata` is zero when no read was issued.
- R6: With kind=1 and sense=0 (rising edge), a synchronized 0→1 transition sets the status bit, and it stays set until cleared.
- R7: With kind=1 and sense=1 (falling edge), a synchronized 1→0 transition sets the status bit, which is sticky.
- R8: With kind=0 and sense=0 (level high), the status bit follows the synchronized level each cycle. A write of one to it has no lasting effect while the level is high.
- R9: With kind=0 and sense=1 (level low), the status bit is the inverse of the synchronized level.
- R10: Writing 1 to an edge-mode status bit clears it, and writing 0 leaves it unchanged.
- R11: If an edge event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R12: `irq` is registered: it equals the OR over all pins of (status AND enable) as of the previous cycle.
- R13: Bits for pins at or above the populated count read as zero and ignore writes. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| pin_in | input | NUM_PINS | Pin levels from the pads (asynchronous) |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt to the parent |

## Verification
The assertions take for granted that the bus strobes are single-cycle and carry aligned word addresses. They also assume `pin_in` reaches the synchronizer as a plain level, so that edge and level results depend only on the synchronized samples. The stimulus drives every bus cycle and pin change on the falling clock edge, holds each access for exactly one cycle, and uses only word-aligned addresses. That includes the unmapped fourth word of each group. The random phase mixes pin toggles with writes to every setting and status word, so clearing writes, trigger-mode changes and edge events collide in the same cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;
    localparam int BANK_W = 2;

    localparam logic [ADDR_W-1:0] BASE_DIR  = 12'h014;
    localparam logic [ADDR_W-1:0] BASE_PAD  = 12'h024;
    localparam logic [ADDR_W-1:0] BASE_IEN  = 12'h044;
    localparam logic [ADDR_W-1:0] BASE_SNS  = 12'h104;
    localparam logic [ADDR_W-1:0] BASE_KND  = 12'h114;
    localparam logic [ADDR_W-1:0] BASE_STAT = 12'h124;

    typedef enum logic [2:0] {
        FEAT_NONE,
        FEAT_DIR,
        FEAT_PAD,
        FEAT_IEN,
        FEAT_SNS,
        FEAT_KND,
        FEAT_STAT
    } feat_e;

    // {kind, sense}
    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'b00,
        TRIG_LVL_LO = 2'b01,
        TRIG_RISE   = 2'b10,
        TRIG_FALL   = 2'b11
    } trig_e;

    typedef struct packed {
        feat_e             feat;
        logic [BANK_W-1:0] bank;
    } decode_t;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base, input int b);
        return base + ADDR_W'(b * 4);
    endfunction

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] addr, input int nbank);
        decode_t d;
        d.feat = FEAT_NONE;
        d.bank = '0;
        for (int b = 0; b < nbank; b++) begin
            if (addr == word_addr(BASE_DIR, b))  begin d.feat = FEAT_DIR;  d.bank = BANK_W'(b); end
            if (addr == word_addr(BASE_PAD, b))  begin d.feat = FEAT_PAD;  d.bank = BANK_W'(b); end
            if (addr == word_addr(BASE_IEN, b))  begin d.feat = FEAT_IEN;  d.bank = BANK_W'(b); end
            if (addr == word_addr(BASE_SNS, b))  begin d.feat = FEAT_SNS;  d.bank = BANK_W'(b); end
            if (addr == word_addr(BASE_KND, b))  begin d.feat = FEAT_KND;  d.bank = BANK_W'(b); end
            if (addr == word_addr(BASE_STAT, b)) begin d.feat = FEAT_STAT; d.bank = BANK_W'(b); end
        end
        return d;
    endfunction

    // Next status bit for one pin given its trigger mode.
    function automatic logic trig_next(input trig_e mode, input logic cur, input logic evt,
                                       input logic held, input logic clr);
        case (mode)
            TRIG_LVL_HI: return cur;
            TRIG_LVL_LO: return ~cur;
            TRIG_RISE,
            TRIG_FALL:   return evt | (held & ~clr);
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W      = 70,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
        dout = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 70
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] cfg_knd,
    input  logic [NUM_PINS-1:0] cfg_sns,
    input  logic [NUM_PINS-1:0] cfg_ien,
    input  logic [NUM_PINS-1:0] stat_clr,
    output logic [NUM_PINS-1:0] status,
    output logic                irq
);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] stat;
        logic                irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] stat_nxt;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign edge_hit[i] = cfg_knd[i] & (cfg_sns[i] ? (~pin_lvl[i] & st_q.prev[i])
                                                      : (pin_lvl[i] & ~st_q.prev[i]));
        assign stat_nxt[i] = trig_next(trig_e'({cfg_knd[i], cfg_sns[i]}), pin_lvl[i],
                                       edge_hit[i], st_q.stat[i], stat_clr[i]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_lvl;
        st_d.stat = stat_nxt;
        st_d.irq  = |(st_q.stat & cfg_ien);
        status    = st_q.stat;
        irq       = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.stat & cfg_knd & ~stat_clr) & ~st_q.stat) == '0)); // R6

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(cfg_knd) & (st_q.stat ^ ($past(pin_lvl) ^ $past(cfg_sns)))) == '0)); // R8

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_hit) & ~st_q.stat) == '0)); // R11

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 70
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] irq_status,
    output logic [NUM_PINS-1:0] cfg_dir,
    output logic [NUM_PINS-1:0] cfg_pad,
    output logic [NUM_PINS-1:0] cfg_ien,
    output logic [NUM_PINS-1:0] cfg_sns,
    output logic [NUM_PINS-1:0] cfg_knd,
    output logic [NUM_PINS-1:0] stat_clr,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                bus_rvalid
);

    localparam int NBANK = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PADW  = NBANK * WORD_W;

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] pad;
        logic [NUM_PINS-1:0] ien;
        logic [NUM_PINS-1:0] sns;
        logic [NUM_PINS-1:0] knd;
        logic [WORD_W-1:0]   rdata;
        logic                rvalid;
    } regs_t;

    regs_t   regs_d, regs_q;
    decode_t dec;
    int      idx;
    logic [PADW-1:0] dir_w, pad_w, ien_w, sns_w, knd_w, clr_w, view_w;

    always_comb begin
        regs_d = regs_q;
        dec    = decode_addr(bus_addr, NBANK);
        idx    = int'(dec.bank);

        dir_w = PADW'(regs_q.dir);
        pad_w = PADW'(regs_q.pad);
        ien_w = PADW'(regs_q.ien);
        sns_w = PADW'(regs_q.sns);
        knd_w = PADW'(regs_q.knd);
        clr_w = '0;

        // read view uses the state before this cycle's write
        case (dec.feat)
            FEAT_DIR:  view_w = dir_w;
            FEAT_PAD:  view_w = PADW'(pin_lvl);
            FEAT_IEN:  view_w = ien_w;
            FEAT_SNS:  view_w = sns_w;
            FEAT_KND:  view_w = knd_w;
            FEAT_STAT: view_w = PADW'(irq_status);
            default:   view_w = '0;
        endcase

        if (bus_we) begin
            case (dec.feat)
                FEAT_DIR:  dir_w[idx*WORD_W +: WORD_W] = bus_wdata;
                FEAT_PAD:  pad_w[idx*WORD_W +: WORD_W] = bus_wdata;
                FEAT_IEN:  ien_w[idx*WORD_W +: WORD_W] = bus_wdata;
                FEAT_SNS:  sns_w[idx*WORD_W +: WORD_W] = bus_wdata;
                FEAT_KND:  knd_w[idx*WORD_W +: WORD_W] = bus_wdata;
                FEAT_STAT: clr_w[idx*WORD_W +: WORD_W] = bus_wdata;
                default:   ;
            endcase
        end

        regs_d.dir    = dir_w[NUM_PINS-1:0];
        regs_d.pad    = pad_w[NUM_PINS-1:0];
        regs_d.ien    = ien_w[NUM_PINS-1:0];
        regs_d.sns    = sns_w[NUM_PINS-1:0];
        regs_d.knd    = knd_w[NUM_PINS-1:0];
        regs_d.rvalid = bus_re;
        regs_d.rdata  = bus_re ? view_w[idx*WORD_W +: WORD_W] : '0;

        stat_clr   = clr_w[NUM_PINS-1:0];
        cfg_dir    = regs_q.dir;
        cfg_pad    = regs_q.pad;
        cfg_ien    = regs_q.ien;
        cfg_sns    = regs_q.sns;
        cfg_knd    = regs_q.knd;
        bus_rdata  = regs_q.rdata;
        bus_rvalid = regs_q.rvalid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> bus_rvalid); // R5

    AST_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> !bus_rvalid); // R5

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(cfg_dir) && $stable(cfg_pad) && $stable(cfg_ien)
                     && $stable(cfg_sns) && $stable(cfg_knd))); // R3

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 70,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] cfg_ien, cfg_sns, cfg_knd;
    logic [NUM_PINS-1:0] stat_clr, status;

    gpio_bank_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_lvl)
    );

    gpio_bank_regs #(
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .pin_lvl    (pin_lvl),
        .irq_status (status),
        .cfg_dir    (pin_oe),
        .cfg_pad    (pin_out),
        .cfg_ien    (cfg_ien),
        .cfg_sns    (cfg_sns),
        .cfg_knd    (cfg_knd),
        .stat_clr   (stat_clr),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    gpio_bank_irq #(
        .NUM_PINS (NUM_PINS)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .cfg_knd  (cfg_knd),
        .cfg_sns  (cfg_sns),
        .cfg_ien  (cfg_ien),
        .stat_clr (stat_clr),
        .status   (status),
        .irq      (irq)
    );

    AST_IRQ_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(status & cfg_ien)))); // R12

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

    localparam int NP = 70;
    localparam int S  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0, re = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [NP-1:0]     pin_in = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic [NP-1:0]     pin_out, pin_oe;
    logic              irq;

    always #2 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int base [6] = '{'h014, 'h024, 'h044, 'h104, 'h114, 'h124};
    bit [95:0] impl = (96'd1 << NP) - 96'd1;
    bit [95:0] m_dir, m_pad, m_ien, m_sns, m_knd, m_stat;
    bit        m_irq, m_rvalid;
    bit [31:0] m_rdata;
    bit [95:0] hist [$];

    function automatic int find_feat(input logic [11:0] a, output int bk);
        bk = 0;
        for (int f = 0; f < 6; f++)
            for (int b = 0; b < 3; b++)
                if (int'(a) == base[f] + 4 * b) begin bk = b; return f; end
        return -1;
    endfunction

    task automatic model_reset();
        m_dir = 0; m_pad = 0; m_ien = 0; m_sns = 0; m_knd = 0; m_stat = 0;
        m_irq = 0; m_rvalid = 0; m_rdata = 0;
        hist.delete();
        for (int k = 0; k <= S; k++) hist.push_back(96'd0);
    endtask

    initial model_reset();

    always @(posedge clk) begin
        bit [95:0] cur, prv, clr, nst, view;
        int f, bk;
        if (!rst_n) begin
            model_reset();
        end else begin
            cur = hist[S-1];
            prv = hist[S];
            f   = find_feat(addr, bk);
            clr = 0;
            if (we && f == 5) clr[bk*32 +: 32] = wdata;
            nst = 0;
            for (int i = 0; i < NP; i++) begin
                if (!m_knd[i]) nst[i] = m_sns[i] ? !cur[i] : cur[i];
                else if (!m_sns[i]) nst[i] = (cur[i] && !prv[i]) || (m_stat[i] && !clr[i]);
                else nst[i] = (!cur[i] && prv[i]) || (m_stat[i] && !clr[i]);
            end
            m_irq = |(m_stat & m_ien);
            case (f)
                0: view = m_dir;
                1: view = cur;
                2: view = m_ien;
                3: view = m_sns;
                4: view = m_knd;
                5: view = m_stat;
                default: view = 0;
            endcase
            m_rvalid = re;
            m_rdata  = re ? view[bk*32 +: 32] : 32'd0;
            if (we) begin
                case (f)
                    0: m_dir[bk*32 +: 32] = wdata;
                    1: m_pad[bk*32 +: 32] = wdata;
                    2: m_ien[bk*32 +: 32] = wdata;
                    3: m_sns[bk*32 +: 32] = wdata;
                    4: m_knd[bk*32 +: 32] = wdata;
                    default: ;
                endcase
                m_dir &= impl; m_pad &= impl; m_ien &= impl; m_sns &= impl; m_knd &= impl;
            end
            m_stat = nst & impl;
            hist.push_front(96'(pin_in));
            void'(hist.pop_back());
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R12 irq", irq, m_irq);
            check("R3 pin_oe", pin_oe, m_dir[NP-1:0]);
            check("R3 pin_out", pin_out, m_pad[NP-1:0]);
            check("R5 rvalid", rvalid, m_rvalid);
            check("R2 rdata", rdata, m_rdata);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); re = 1; addr = a;
        @(negedge clk); re = 0;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        idle(3);
        check("R1 irq", irq, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_out", pin_out, 0);
        rst_n = 1;
        rd(12'h014, 0, "R1 dir0");
        rd(12'h12C, 0, "R1 stat2");
        rd(12'h118, 0, "R1 kind1");

        // direction and output value
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd(12'h01C, 32'h0000_003F, "R13 dir2 upper bits");
        check("R3 pin_oe bank0", pin_oe[31:0], 32'hFFFF_FFFF);
        check("R3 pin_oe bank1", pin_oe[63:32], 0);
        wr(12'h024, 32'hA5A5_A5A5);
        check("R3 pin_out bank0", pin_out[31:0], 32'hA5A5_A5A5);
        wr(12'h00C, 32'h1234_5678);
        rd(12'h00C, 0, "R13 unmapped");
        rd(12'h020, 0, "R13 fourth dir word");

        // synchronized level readback
        pin_in = {6'h2A, 32'hDEAD_BEEF, 32'h0F0F_1234};
        rd(12'h028, 0, "R4 old level during sync");
        rd(12'h028, 32'hDEAD_BEEF, "R4 level bank1");
        rd(12'h02C, 32'h0000_002A, "R4 level bank2");
        pin_in = '0;
        idle(4);

        // trigger setup: pin0 rise, pin33 fall, pin65 level high, pin69 level low
        wr(12'h114, 32'h0000_0001);
        wr(12'h118, 32'h0000_0002);
        wr(12'h104, 32'h0000_0000);
        wr(12'h108, 32'h0000_0002);
        wr(12'h10C, 32'h0000_0020);
        wr(12'h044, 32'h0000_0001);
        wr(12'h048, 32'h0000_0002);
        wr(12'h04C, 32'h0000_0022);
        idle(2);
        rd(12'h12C, 32'h0000_0020, "R9 level low active");
        check("R9 irq from level low", irq, 1);
        wr(12'h12C, 32'h0000_0020);
        idle(1);
        rd(12'h12C, 32'h0000_0020, "R8 clear has no lasting effect on level");
        pin_in[69] = 1;
        idle(4);
        rd(12'h12C, 0, "R9 level low released");
        check("R12 irq idle", irq, 0);

        // rising edge
        pin_in[0] = 1;
        idle(4);
        rd(12'h124, 32'h1, "R6 rising sets");
        pin_in[0] = 0;
        idle(4);
        rd(12'h124, 32'h1, "R6 sticky after fall");
        check("R12 irq from edge", irq, 1);
        wr(12'h124, 32'h0);
        rd(12'h124, 32'h1, "R10 write zero keeps");
        wr(12'h124, 32'h1);
        idle(1);
        rd(12'h124, 32'h0, "R10 write one clears");

        // falling edge
        pin_in[33] = 1;
        idle(4);
        rd(12'h128, 32'h0, "R7 rise ignored");
        pin_in[33] = 0;
        idle(4);
        rd(12'h128, 32'h2, "R7 fall sets");
        wr(12'h048, 32'h0);
        idle(2);
        check("R12 masked pending", irq, 0);
        rd(12'h128, 32'h2, "R12 status kept while masked");
        wr(12'h128, 32'h2);

        // level high
        pin_in[65] = 1;
        idle(4);
        rd(12'h12C, 32'h2, "R8 level high follows");
        check("R12 irq level high", irq, 1);
        pin_in[65] = 0;
        idle(4);
        rd(12'h12C, 32'h0, "R8 level high drops");

        // edge and clear in the same cycle: event must win
        pin_in[0] = 1;
        idle(1);
        wr(12'h124, 32'h1);
        rd(12'h124, 32'h1, "R11 event beats clear");
        wr(12'h124, 32'h1);
        pin_in[0] = 0;

        // upper bits of last word ignore writes
        wr(12'h11C, 32'hFFFF_FFFF);
        rd(12'h11C, 32'h0000_003F, "R13 kind2 upper bits");
        wr(12'h11C, 32'h0);
        idle(4);

        // random phase, checked every cycle against the model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) pin_in[$urandom_range(0, NP-1)] ^= 1'b1;
            we = ($urandom_range(0, 3) == 0);
            re = ($urandom_range(0, 2) == 0);
            addr = 12'(base[$urandom_range(0, 5)] + 4 * $urandom_range(0, 3));
            wdata = $urandom();
        end
        @(negedge clk);
        we = 0; re = 0;
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule